// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block runs the refill of one cache line after a miss. A line holds four 64-bit double words, so a refill is a burst of four beats. The memory side is asked for the double word that missed first, and the rest of the line follows in wrapping order. For example, a miss on double word 2 brings the beats in as 2, 3, 0, 1. Each beat is written into the data array as it arrives.

The requester gets the missed double word in the same cycle that it is written into the array. A fill started by an instruction fetch also forwards every later beat to the fetch queue. A fill started by a data read, or by a store miss that reads with intent to modify, forwards only the critical beat.

While the fill is in progress, lookups that hit go ahead. The only exception is a lookup to a double word of the line being filled that has not yet been written; it is held off. Only one fill can be outstanding at a time. After the last beat is written, a one-cycle completion pulse gives the set and way, so the replacement logic can mark the line valid.

Top module: `line_fill_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1, and `mem_req_valid`, `arr_we`, `fwd_valid`, `fwd_crit` and `done_valid` are all 0.
- R2: Addresses are split into three fields: byte offset in bits [2:0], double-word index in bits [4:3], and line number in bits [31:5]. A miss accepted on a clock edge (`miss_valid` and `miss_ready` both high) makes `mem_req_valid` high for exactly the next cycle. In that cycle, `mem_req_addr` is the miss address with bits [2:0] cleared, and `mem_req_excl` equals `miss_write`.
- R3: The k-th accepted beat (k = 0..3) produces `arr_we` in the cycle after it arrives. In that cycle, `arr_beat` = (critical index + k) mod 4, `arr_wdata` equals the beat data, `arr_set` equals line-number bits [6:0] (address bits [11:5]), and `arr_way` is the miss way.
- R4: The first beat is forwarded in the same cycle as its array write: `fwd_valid`=1, `fwd_crit`=1, `fwd_data` = beat data, and `fwd_tag` = the miss tag. `fwd_crit` is 0 for every other beat.
- R5: When `miss_ifetch`=1, all four beats are forwarded in arrival order, each alongside its array write. When `miss_ifetch`=0, only the first beat is forwarded.
- R6: From the edge that accepts a miss until the completion pulse, `miss_ready` is 0. A miss presented during that time produces no memory request.
- R7: During a fill, a lookup (`hit_valid`=1) whose line number differs from the filling line gets `hit_go`=1 in the same cycle.
- R8: A lookup to the filling line gets `hit_go`=0 until the cycle after the array write of the double word it addresses, and `hit_go`=1 from then on. With no fill in progress, `hit_go` equals `hit_valid`.
- R9: `done_valid` is high for one cycle, the cycle after the fourth array write. During that pulse, `done_set` and `done_way` give the set and way of the filled line, and `miss_ready` is 1 again.
- R10: `mem_beat_valid` while no fill is in progress has no effect: no array write and no forward follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle, miss can be taken |
| miss_addr | input | 32 | Byte address that missed |
| miss_tag | input | 4 | Requester tag returned with forwarded data |
| miss_way | input | 3 | Way chosen for the refill |
| miss_ifetch | input | 1 | Miss comes from instruction fetch |
| miss_write | input | 1 | Miss is a store that reads with intent to modify |
| mem_req_valid | output | 1 | One-cycle burst read request |
| mem_req_addr | output | 32 | Burst start address (critical double word) |
| mem_req_excl | output | 1 | Request reads with intent to modify |
| mem_beat_valid | input | 1 | Beat data present |
| mem_beat_data | input | 64 | Beat data |
| arr_we | output | 1 | Data array write enable |
| arr_set | output | 7 | Data array set index |
| arr_way | output | 3 | Data array way |
| arr_beat | output | 2 | Double word within the line |
| arr_wdata | output | 64 | Data array write data |
| fwd_valid | output | 1 | Forwarded data valid |
| fwd_crit | output | 1 | Forwarded beat is the critical one |
| fwd_tag | output | 4 | Requester tag |
| fwd_data | output | 64 | Forwarded double word |
| hit_valid | input | 1 | Lookup that hit wants to proceed |
| hit_addr | input | 32 | Lookup address |
| hit_go | output | 1 | Lookup may proceed this cycle |
| done_valid | output | 1 | Fill complete pulse |
| done_set | output | 7 | Set of the completed line |
| done_way | output | 3 | Way of the completed line |

## Verification
The assertions assume three things about the memory side. It returns exactly four beats per request. It sends no beat before the request. It sends no fifth beat that would run past the line. The write-order and completion checks depend on all three. They also assume `hit_valid` is only raised for a lookup that really hit, so `hit_go` stands for permission and nothing more. The stimulus keeps within these limits: it sends one beat per request cycle slot, spaced by idle cycles, for each critical index crossed with each fetch and write-intent combination. Beats sent while idle, and a second miss sent during a fill, are there only to check that they are ignored.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic {
    KIND_DATA  = 1'b0,
    KIND_FETCH = 1'b1
  } fill_kind_e;
endpackage

// File: rtl/lf_beat_seq.sv
module lf_beat_seq #(
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy,
  input  logic [IDX_W-1:0] crit_idx,
  input  logic             beat_valid,
  output logic             take,
  output logic [IDX_W-1:0] take_idx,
  output logic             take_first,
  output logic             take_last
);
  logic [IDX_W:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start) cnt_q <= '0;
    else if (take)    cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    take       = beat_valid && busy && (cnt_q < (IDX_W+1)'(BEATS));
    take_idx   = crit_idx + cnt_q[IDX_W-1:0];
    take_first = (cnt_q == '0);
    take_last  = (cnt_q == (IDX_W+1)'(BEATS-1));
  end
endmodule

// File: rtl/lf_written_mask.sv
module lf_written_mask #(
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic [BEATS-1:0] mask
);
  for (genvar b = 0; b < BEATS; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst || clear)                          bit_q <= 1'b0;
      else if (set_en && set_idx == IDX_W'(b))   bit_q <= 1'b1;
    end
    assign mask[b] = bit_q;
  end
endmodule

// File: rtl/lf_hit_guard.sv
module lf_hit_guard #(
  parameter int LINE_W = 27,
  parameter int BEATS  = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic              busy,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [BEATS-1:0]  written,
  input  logic              hit_valid,
  input  logic [LINE_W-1:0] hit_line,
  input  logic [IDX_W-1:0]  hit_idx,
  output logic              hit_go
);
  logic same_line;
  always_comb begin
    same_line = busy && (hit_line == fill_line);
    hit_go    = hit_valid && !(same_line && !written[hit_idx]);
  end
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  parameter int SET_W  = 7,
  parameter int WAY_W  = 3,
  parameter int TAG_W  = 4,
  localparam int OFF_W    = $clog2(DATA_W/8),
  localparam int IDX_W    = $clog2(BEATS),
  localparam int LINE_LSB = OFF_W + IDX_W,
  localparam int LINE_W   = ADDR_W - LINE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [TAG_W-1:0]  miss_tag,
  input  logic [WAY_W-1:0]  miss_way,
  input  logic              miss_ifetch,
  input  logic              miss_write,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_excl,
  input  logic              mem_beat_valid,
  input  logic [DATA_W-1:0] mem_beat_data,
  output logic              arr_we,
  output logic [SET_W-1:0]  arr_set,
  output logic [WAY_W-1:0]  arr_way,
  output logic [IDX_W-1:0]  arr_beat,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              fwd_valid,
  output logic              fwd_crit,
  output logic [TAG_W-1:0]  fwd_tag,
  output logic [DATA_W-1:0] fwd_data,
  input  logic              hit_valid,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              hit_go,
  output logic              done_valid,
  output logic [SET_W-1:0]  done_set,
  output logic [WAY_W-1:0]  done_way
);
  import lf_pkg::*;

  logic              busy_q;
  logic [LINE_W-1:0] line_q;
  logic [IDX_W-1:0]  crit_q;
  logic [TAG_W-1:0]  tag_q;
  logic [WAY_W-1:0]  way_q;
  fill_kind_e        kind_q;
  logic              last_q;
  logic              accept;
  logic              take, take_first, take_last;
  logic [IDX_W-1:0]  take_idx;
  logic [BEATS-1:0]  written;
  logic              lf_unused;

  assign lf_unused  = ^{miss_addr[OFF_W-1:0], hit_addr[OFF_W-1:0]};
  assign accept     = miss_valid && !busy_q;
  assign miss_ready = !busy_q;

  lf_beat_seq #(.BEATS(BEATS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .busy       (busy_q),
    .crit_idx   (crit_q),
    .beat_valid (mem_beat_valid),
    .take       (take),
    .take_idx   (take_idx),
    .take_first (take_first),
    .take_last  (take_last)
  );

  lf_written_mask #(.BEATS(BEATS)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .set_en  (arr_we),
    .set_idx (arr_beat),
    .mask    (written)
  );

  lf_hit_guard #(.LINE_W(LINE_W), .BEATS(BEATS)) u_guard (
    .busy      (busy_q),
    .fill_line (line_q),
    .written   (written),
    .hit_valid (hit_valid),
    .hit_line  (hit_addr[ADDR_W-1:LINE_LSB]),
    .hit_idx   (hit_addr[LINE_LSB-1:OFF_W]),
    .hit_go    (hit_go)
  );

  // Control path: reset to idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q        <= 1'b0;
      mem_req_valid <= 1'b0;
      arr_we        <= 1'b0;
      fwd_valid     <= 1'b0;
      fwd_crit      <= 1'b0;
      last_q        <= 1'b0;
      done_valid    <= 1'b0;
    end else begin
      mem_req_valid <= accept;
      arr_we        <= take;
      fwd_valid     <= take && (take_first || kind_q == KIND_FETCH);
      fwd_crit      <= take && take_first;
      last_q        <= take && take_last;
      done_valid    <= arr_we && last_q;
      if (accept)                busy_q <= 1'b1;
      else if (arr_we && last_q) busy_q <= 1'b0;
    end
  end

  // Data path: no reset, qualified by the valids above.
  always_ff @(posedge clk) begin
    if (accept) begin
      line_q       <= miss_addr[ADDR_W-1:LINE_LSB];
      crit_q       <= miss_addr[LINE_LSB-1:OFF_W];
      tag_q        <= miss_tag;
      way_q        <= miss_way;
      kind_q       <= miss_ifetch ? KIND_FETCH : KIND_DATA;
      mem_req_addr <= {miss_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      mem_req_excl <= miss_write;
    end
    if (take) begin
      arr_beat  <= take_idx;
      arr_wdata <= mem_beat_data;
      fwd_data  <= mem_beat_data;
    end
  end

  assign arr_set  = line_q[SET_W-1:0];
  assign arr_way  = way_q;
  assign fwd_tag  = tag_q;
  assign done_set = line_q[SET_W-1:0];
  assign done_way = way_q;
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int OFF_W = $clog2(DATA_W/8),
  localparam int IDX_W = $clog2(BEATS)
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              arr_we,
  input logic [IDX_W-1:0]  arr_beat,
  input logic [DATA_W-1:0] arr_wdata,
  input logic              fwd_valid,
  input logic              fwd_crit,
  input logic [DATA_W-1:0] fwd_data,
  input logic              hit_valid,
  input logic              hit_go,
  input logic              done_valid
);
  logic [IDX_W-1:0] prev_beat;
  logic [IDX_W:0]   wr_cnt;

  always_ff @(posedge clk) begin
    if (rst)         prev_beat <= '0;
    else if (arr_we) prev_beat <= arr_beat;
  end

  always_ff @(posedge clk) begin
    if (rst || done_valid) wr_cnt <= '0;
    else if (arr_we)       wr_cnt <= wr_cnt + 1'b1;
  end

  AST_REQ_FOLLOWS_MISS: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> (mem_req_valid &&
      mem_req_addr[ADDR_W-1:OFF_W] == $past(miss_addr[ADDR_W-1:OFF_W]))); // R2
  AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (arr_we && !fwd_crit) |-> arr_beat == IDX_W'(prev_beat + 1'b1)); // R3
  AST_CRIT_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    fwd_crit |-> (arr_we && fwd_valid && fwd_data == arr_wdata)); // R4
  AST_FWD_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (arr_we && fwd_data == arr_wdata)); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !miss_ready); // R6
  AST_IDLE_HIT_GOES: assert property (@(posedge clk) disable iff (rst)
    (hit_valid && miss_ready) |-> hit_go); // R8
  AST_DONE_AFTER_FOUR: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (wr_cnt == (IDX_W+1)'(BEATS) && miss_ready)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R9
endmodule

bind line_fill_ctrl lf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_lf_checker (
  .clk           (clk),
  .rst           (rst),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .miss_addr     (miss_addr),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .arr_we        (arr_we),
  .arr_beat      (arr_beat),
  .arr_wdata     (arr_wdata),
  .fwd_valid     (fwd_valid),
  .fwd_crit      (fwd_crit),
  .fwd_data      (fwd_data),
  .hit_valid     (hit_valid),
  .hit_go        (hit_go),
  .done_valid    (done_valid)
);

// File: tb/test_line_fill_ctrl.sv
module test_line_fill_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_addr = '0;
  logic [3:0]  miss_tag = '0;
  logic [2:0]  miss_way = '0;
  logic        miss_ifetch = 1'b0;
  logic        miss_write = 1'b0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_excl;
  logic        mem_beat_valid = 1'b0;
  logic [63:0] mem_beat_data = '0;
  logic        arr_we;
  logic [6:0]  arr_set;
  logic [2:0]  arr_way;
  logic [1:0]  arr_beat;
  logic [63:0] arr_wdata;
  logic        fwd_valid, fwd_crit;
  logic [3:0]  fwd_tag;
  logic [63:0] fwd_data;
  logic        hit_valid = 1'b0;
  logic [31:0] hit_addr = '0;
  logic        hit_go;
  logic        done_valid;
  logic [6:0]  done_set;
  logic [2:0]  done_way;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  line_fill_ctrl i_line_fill_ctrl (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(miss_ready == 1'b1, "R1 ready", 64'(miss_ready), 1);
    chk({mem_req_valid, arr_we, fwd_valid, fwd_crit, done_valid} == 5'b0, "R1 idle outputs",
        64'({mem_req_valid, arr_we, fwd_valid, fwd_crit, done_valid}), 0);
    hit_valid = 1'b1; hit_addr = 32'h0000_1000; #1;
    chk(hit_go == 1'b1, "R8 idle lookup", 64'(hit_go), 1);
    hit_valid = 1'b0;
    // R10 beat while idle
    mem_beat_valid = 1'b1; mem_beat_data = 64'hDEAD;
    @(negedge clk);
    mem_beat_valid = 1'b0;
    chk(arr_we == 1'b0 && fwd_valid == 1'b0, "R10 idle beat ignored", 64'({arr_we, fwd_valid}), 0);

    for (int crit = 0; crit < 4; crit++) begin
      for (int mode = 0; mode < 4; mode++) begin
        logic [26:0] line;
        logic        ifetch, wr;
        logic [3:0]  tag;
        logic [2:0]  way;
        line   = 27'h0012_340 + 27'(crit * 4 + mode);
        ifetch = mode[0];
        wr     = mode[1];
        tag    = 4'(crit * 4 + mode);
        way    = 3'(crit + mode);
        miss_valid = 1'b1; miss_addr = {line, 2'(crit), 3'b101};
        miss_tag = tag; miss_way = way; miss_ifetch = ifetch; miss_write = wr;
        @(negedge clk);
        chk(mem_req_valid == 1'b1, "R2 request pulse", 64'(mem_req_valid), 1);
        chk(mem_req_addr == {line, 2'(crit), 3'b000}, "R2 request address",
            64'(mem_req_addr), 64'({line, 2'(crit), 3'b000}));
        chk(mem_req_excl == wr, "R2 intent to modify", 64'(mem_req_excl), 64'(wr));
        chk(miss_ready == 1'b0, "R6 busy", 64'(miss_ready), 0);
        miss_addr = {line + 27'd100, 5'd0};
        hit_valid = 1'b1; hit_addr = {line + 27'd77, 2'(crit), 3'b0}; #1;
        chk(hit_go == 1'b1, "R7 other line during fill", 64'(hit_go), 1);
        hit_addr = {line, 2'(crit), 3'b0}; #1;
        chk(hit_go == 1'b0, "R8 filling line blocked", 64'(hit_go), 0);
        @(negedge clk);
        chk(mem_req_valid == 1'b0, "R6 second miss held", 64'(mem_req_valid), 0);
        miss_valid = 1'b0; hit_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
          logic [1:0]  idx;
          logic [63:0] d;
          logic        fexp;
          idx  = 2'((crit + k) % 4);
          d    = 64'hC0DE_0000_0000_0000 | 64'(crit << 16) | 64'(mode << 8) | 64'(k);
          fexp = (k == 0) || ifetch;
          mem_beat_valid = 1'b1; mem_beat_data = d;
          @(negedge clk);
          mem_beat_valid = 1'b0;
          chk(arr_we == 1'b1, "R3 write enable", 64'(arr_we), 1);
          chk(arr_beat == idx, "R3 wrap order", 64'(arr_beat), 64'(idx));
          chk(arr_wdata == d, "R3 write data", arr_wdata, d);
          chk(arr_set == line[6:0] && arr_way == way, "R3 set and way",
              64'({arr_set, arr_way}), 64'({line[6:0], way}));
          chk(fwd_valid == fexp, "R5 forward select", 64'(fwd_valid), 64'(fexp));
          chk(fwd_crit == (k == 0), "R4 critical flag", 64'(fwd_crit), 64'(k == 0));
          if (fexp) begin
            chk(fwd_data == d && fwd_tag == tag, "R4 forward data and tag",
                fwd_data ^ 64'(fwd_tag), d ^ 64'(tag));
          end
          hit_valid = 1'b1; hit_addr = {line, idx, 3'b0}; #1;
          chk(hit_go == 1'b0, "R8 blocked during write", 64'(hit_go), 0);
          @(negedge clk);
          #1;
          chk(hit_go == 1'b1, "R8 granted after write", 64'(hit_go), 1);
          hit_valid = 1'b0;
          chk(arr_we == 1'b0, "R3 single write per beat", 64'(arr_we), 0);
          if (k == 3) begin
            chk(done_valid == 1'b1 && miss_ready == 1'b1, "R9 done pulse",
                64'({done_valid, miss_ready}), 3);
            chk(done_set == line[6:0] && done_way == way, "R9 done set and way",
                64'({done_set, done_way}), 64'({line[6:0], way}));
          end else begin
            chk(done_valid == 1'b0 && miss_ready == 1'b0, "R6 still busy",
                64'({done_valid, miss_ready}), 0);
          end
        end
        @(negedge clk);
        chk(done_valid == 1'b0, "R9 one-cycle pulse", 64'(done_valid), 0);
      end
    end

    // R10 beat after completion
    mem_beat_valid = 1'b1; mem_beat_data = 64'hBEEF;
    @(negedge clk);
    mem_beat_valid = 1'b0;
    chk(arr_we == 1'b0 && fwd_valid == 1'b0, "R10 stray beat ignored", 64'({arr_we, fwd_valid}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule